// File: doc/BRIEF.md
# Submission/Completion Queue Pair Engine

This block is the device-side engine for one pair of ring queues that live in host memory: a submission ring of 64-byte command entries and a completion ring of 16-byte result entries. The host moves two indices by register writes: the submission tail, after it has placed new commands, and the completion head, after it has consumed results. The engine owns the other two indices. It advances the submission head as it reads commands and the completion tail as it writes results. It reports its submission head back to the host inside every completion entry.

Commands between the engine's head and the host's tail are read one at a time, in ring order, through a single host-memory request/response port. Each one is then offered on a valid/ready command stream to a downstream processor. The processor returns results on a valid/ready completion stream. The engine turns each result into a completion entry, writes it into the completion ring and then pulses an interrupt request. It never writes a slot the host has not released. The ring size is a run-time configuration input of up to 65535 entries. All indices wrap to zero at that size.

Back-pressure works as follows. A source raising `mreq_valid` or `cmd_valid` keeps it high, with its payload unchanged, until the cycle in which the matching ready is high. `cpl_ready` is low whenever the completion ring is full or a previous entry is still being written. A memory write is complete once accepted and gets no response. A read gets exactly one `mrsp_valid` cycle, which may come any number of cycles after acceptance.

Top module: `qpair_engine`

## Requirements
- R1: After reset `irq`, `cmd_valid`, `mreq_valid` and `db_err` are low and `cpl_ready` is high; all four indices are zero.
- R2: A command read is a request with `mreq_write` low at address `cfg_sq_base + 64*head`; no second read is requested until the response to the first has arrived.
- R3: Reads are issued only while submission head differs from tail, in ring order, and exactly one per pending entry, including across the wrap from `cfg_qsize-1` to 0.
- R4: `cmd_data` equals the 512-bit response of the read, and it stays stable with `cmd_valid` high until `cmd_ready` is seen; no further read starts while a command is held.
- R5: A completion is written with `mreq_write` high at `cfg_cq_base + 16*tail`. The entry holds the command identifier in bits 15:0, the submission head at acceptance time in bits 31:16, the status in bits 46:32, the phase in bit 47, and zeros above.
- R6: The phase written is 1 until the completion tail first wraps to zero, and it inverts on every later wrap.
- R7: `cpl_ready` is low while tail+1 (mod `cfg_qsize`) equals the completion head; a completion held at the port then waits, and it is written once a head doorbell frees a slot.
- R8: `irq` is high for exactly one cycle, in the cycle after the memory port accepts a completion write.
- R9: A doorbell write (`db_sel` 0 = submission tail, 1 = completion head) whose value is not below `cfg_qsize` changes no index and sets `db_err`, which then stays set until reset.
- R10: While `mreq_valid` is high and `mreq_ready` low, the request (write flag, address, data) holds unchanged; when reads and writes compete, the pending completion write goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_qsize | input | 17 | Entries per ring (2..65535) |
| cfg_sq_base | input | 64 | Byte address of submission ring |
| cfg_cq_base | input | 64 | Byte address of completion ring |
| db_valid | input | 1 | Doorbell write strobe |
| db_sel | input | 1 | 0: submission tail, 1: completion head |
| db_data | input | 16 | New index value |
| db_err | output | 1 | Sticky out-of-range doorbell flag |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 write, 0 read |
| mreq_addr | output | 64 | Byte address |
| mreq_wdata | output | 128 | Completion entry for writes |
| mrsp_valid | input | 1 | Read response valid |
| mrsp_data | input | 512 | Read response (one command entry) |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Processor takes command |
| cmd_data | output | 512 | Command entry |
| cpl_valid | input | 1 | Completion result valid |
| cpl_ready | output | 1 | Engine takes result |
| cpl_cid | input | 16 | Command identifier of the result |
| cpl_status | input | 15 | Status of the result |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench drives `cfg_qsize` with 4, so both rings wrap after a few entries. The submission head passes zero twice, the completion phase flips, and the completion ring reaches its full state after three entries. Bases of 0x1000 and 0x8000 keep the expected addresses easy to read. A doorbell value of 4 lies exactly on the range bound. A toggling memory-ready pattern makes command reads and completion writes contend for the port while requests are stalled.

// File: rtl/qpe_pkg.sv
package qpe_pkg;
  localparam int IDX_W     = 16;
  localparam int ADDR_W    = 64;
  localparam int CMD_BYTES = 64;
  localparam int CPL_BYTES = 16;
  localparam int CMD_W     = CMD_BYTES * 8;
  localparam int CPL_W     = CPL_BYTES * 8;
  localparam int CMD_SHIFT = $clog2(CMD_BYTES);
  localparam int CPL_SHIFT = $clog2(CPL_BYTES);
  localparam int STAT_W    = 15;
  localparam int CID_W     = 16;
  localparam int PAD_W     = CPL_W - CID_W - IDX_W - STAT_W - 1;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [IDX_W:0]   qsz_t;

  // completion entry, least significant field last
  typedef struct packed {
    logic [PAD_W-1:0]  pad;
    logic              phase;
    logic [STAT_W-1:0] status;
    idx_t              sqhd;
    logic [CID_W-1:0]  cid;
  } cpl_entry_t;

  function automatic idx_t idx_next(input idx_t i, input qsz_t qs);
    qsz_t n;
    n = {1'b0, i} + 1'b1;
    if (n >= qs) return '0;
    return n[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/qpe_doorbell.sv
module qpe_doorbell import qpe_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  qsz_t cfg_qsize,
  input  logic db_valid,
  input  logic db_sel,
  input  idx_t db_data,
  output idx_t sq_tail,
  output idx_t cq_head,
  output logic db_err
);
  logic in_range;
  assign in_range = ({1'b0, db_data} < cfg_qsize);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_tail <= '0;
      cq_head <= '0;
      db_err  <= 1'b0;
    end else if (db_valid) begin
      if (!in_range)    db_err  <= 1'b1;
      else if (db_sel)  cq_head <= db_data;
      else              sq_tail <= db_data;
    end
  end
endmodule

// File: rtl/qpe_fetch.sv
module qpe_fetch import qpe_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  qsz_t              cfg_qsize,
  input  logic [ADDR_W-1:0] cfg_sq_base,
  input  idx_t              sq_tail,
  output idx_t              sq_head,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [CMD_W-1:0]  rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data
);
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_HOLD} fst_t;
  fst_t st;
  logic [CMD_W-1:0] cmd_q;

  assign req_valid = (st == F_REQ);
  assign req_addr  = cfg_sq_base + (ADDR_W'(sq_head) << CMD_SHIFT);
  assign cmd_valid = (st == F_HOLD);
  assign cmd_data  = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= F_IDLE;
      sq_head <= '0;
      cmd_q   <= '0;
    end else begin
      case (st)
        F_IDLE: if (sq_head != sq_tail) st <= F_REQ;
        F_REQ:  if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          cmd_q   <= rsp_data;
          sq_head <= idx_next(sq_head, cfg_qsize);
          st      <= F_HOLD;
        end
        F_HOLD: if (cmd_ready) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpe_post.sv
module qpe_post import qpe_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  qsz_t              cfg_qsize,
  input  logic [ADDR_W-1:0] cfg_cq_base,
  input  idx_t              cq_head,
  input  idx_t              sq_head,
  output idx_t              cq_tail,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [CID_W-1:0]  cpl_cid,
  input  logic [STAT_W-1:0] cpl_status,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CPL_W-1:0]  req_wdata,
  output logic              irq
);
  typedef enum logic {P_IDLE, P_WR} pst_t;
  pst_t       st;
  cpl_entry_t ent_q;
  logic       phase_q;
  logic       ring_full;
  idx_t       tail_nx;

  assign tail_nx   = idx_next(cq_tail, cfg_qsize);
  assign ring_full = (tail_nx == cq_head);
  assign cpl_ready = (st == P_IDLE) && !ring_full;
  assign req_valid = (st == P_WR);
  assign req_addr  = cfg_cq_base + (ADDR_W'(cq_tail) << CPL_SHIFT);
  assign req_wdata = ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      ent_q   <= '0;
      phase_q <= 1'b1;
      cq_tail <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        P_IDLE: if (cpl_valid && cpl_ready) begin
          ent_q.pad    <= '0;
          ent_q.phase  <= phase_q;
          ent_q.status <= cpl_status;
          ent_q.sqhd   <= sq_head;
          ent_q.cid    <= cpl_cid;
          st           <= P_WR;
        end
        P_WR: if (req_ready) begin
          cq_tail <= tail_nx;
          if (tail_nx == '0) phase_q <= ~phase_q;
          irq <= 1'b1;
          st  <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpe_mem_arb.sv
module qpe_mem_arb import qpe_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_valid,
  output logic              f_ready,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              p_valid,
  output logic              p_ready,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [CPL_W-1:0]  p_wdata,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [CPL_W-1:0]  mreq_wdata
);
  logic hold_q, own_post_q, pick_post;

  // a stalled request keeps its owner; otherwise writes win
  assign pick_post  = hold_q ? own_post_q : p_valid;
  assign mreq_valid = pick_post ? p_valid : f_valid;
  assign mreq_write = pick_post;
  assign mreq_addr  = pick_post ? p_addr : f_addr;
  assign mreq_wdata = pick_post ? p_wdata : '0;
  assign p_ready    = pick_post & mreq_ready;
  assign f_ready    = ~pick_post & mreq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      own_post_q <= 1'b0;
    end else if (mreq_valid && !mreq_ready) begin
      hold_q     <= 1'b1;
      own_post_q <= pick_post;
    end else begin
      hold_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/qpair_engine.sv
module qpair_engine import qpe_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W:0]    cfg_qsize,
  input  logic [ADDR_W-1:0] cfg_sq_base,
  input  logic [ADDR_W-1:0] cfg_cq_base,
  input  logic              db_valid,
  input  logic              db_sel,
  input  logic [IDX_W-1:0]  db_data,
  output logic              db_err,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [CPL_W-1:0]  mreq_wdata,
  input  logic              mrsp_valid,
  input  logic [CMD_W-1:0]  mrsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [CID_W-1:0]  cpl_cid,
  input  logic [STAT_W-1:0] cpl_status,
  output logic              irq
);
  idx_t sq_head, sq_tail, cq_head, cq_tail;
  logic              f_valid, f_ready, p_valid, p_ready;
  logic [ADDR_W-1:0] f_addr, p_addr;
  logic [CPL_W-1:0]  p_wdata;

  qpe_doorbell u_db (
    .clk(clk), .rst_n(rst_n), .cfg_qsize(cfg_qsize),
    .db_valid(db_valid), .db_sel(db_sel), .db_data(db_data),
    .sq_tail(sq_tail), .cq_head(cq_head), .db_err(db_err)
  );

  qpe_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_qsize(cfg_qsize), .cfg_sq_base(cfg_sq_base),
    .sq_tail(sq_tail), .sq_head(sq_head),
    .req_valid(f_valid), .req_ready(f_ready), .req_addr(f_addr),
    .rsp_valid(mrsp_valid), .rsp_data(mrsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  qpe_post u_post (
    .clk(clk), .rst_n(rst_n), .cfg_qsize(cfg_qsize), .cfg_cq_base(cfg_cq_base),
    .cq_head(cq_head), .sq_head(sq_head), .cq_tail(cq_tail),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_cid(cpl_cid), .cpl_status(cpl_status),
    .req_valid(p_valid), .req_ready(p_ready), .req_addr(p_addr),
    .req_wdata(p_wdata), .irq(irq)
  );

  qpe_mem_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .f_valid(f_valid), .f_ready(f_ready), .f_addr(f_addr),
    .p_valid(p_valid), .p_ready(p_ready), .p_addr(p_addr), .p_wdata(p_wdata),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata)
  );
endmodule

// File: rtl/qpe_checker.sv
module qpe_checker import qpe_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W:0]    cfg_qsize,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic              mreq_write,
  input logic [ADDR_W-1:0] mreq_addr,
  input logic [CPL_W-1:0]  mreq_wdata,
  input logic              mrsp_valid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_data,
  input logic              irq,
  input logic              db_err,
  input idx_t              sq_head,
  input idx_t              sq_tail,
  input idx_t              cq_head,
  input idx_t              cq_tail
);
  logic rd_pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (mreq_valid && mreq_ready && !mreq_write) rd_pend <= 1'b1;
    else if (mrsp_valid) rd_pend <= 1'b0;
  end

  assert_one_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_write) |-> !rd_pend);

  assert_fetch_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_write) |-> (sq_head != sq_tail));

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_write) |-> (idx_next(cq_tail, cfg_qsize) != cq_head));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mreq_valid && mreq_ready && mreq_write));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_write)
      && $stable(mreq_addr) && $stable(mreq_wdata)));
endmodule

bind qpair_engine qpe_checker u_chk (.*);

// File: tb/sim_qpair_engine.sv
`timescale 1ns/1ps
module sim_qpair_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [16:0]   cfg_qsize;
  logic [63:0]   cfg_sq_base, cfg_cq_base;
  logic          db_valid, db_sel;
  logic [15:0]   db_data;
  logic          db_err;
  logic          mreq_valid, mreq_ready, mreq_write;
  logic [63:0]   mreq_addr;
  logic [127:0]  mreq_wdata;
  logic          mrsp_valid;
  logic [511:0]  mrsp_data;
  logic          cmd_valid, cmd_ready;
  logic [511:0]  cmd_data;
  logic          cpl_valid, cpl_ready;
  logic [15:0]   cpl_cid;
  logic [14:0]   cpl_status;
  logic          irq;

  qpair_engine u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0]  cyc = 0;
  int           rdy_mode = 0;
  int           rd_timer = 0;
  logic [63:0]  rd_addr_q;
  logic [63:0]  rd_log [0:31];
  logic [63:0]  wr_addr [0:31];
  logic [127:0] wr_data [0:31];
  logic [511:0] cmd_log [0:31];
  int n_rd = 0, n_wr = 0, n_cmd = 0, irq_cnt = 0, irq_dbl = 0, stab_viol = 0;
  bit irq_prev = 0, prev_wait = 0, prev_write = 0;
  logic [63:0]  prev_addr;
  logic [127:0] prev_wdata;

  // memory model and monitors, all on the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    mreq_ready = (rdy_mode == 0) ? 1'b1 : cyc[0];
    mrsp_valid = 1'b0;
    if (rd_timer != 0) begin
      rd_timer = rd_timer - 1;
      if (rd_timer == 0) begin
        mrsp_valid = 1'b1;
        mrsp_data  = {8{rd_addr_q}};
      end
    end
    if (prev_wait && !(mreq_valid && mreq_addr == prev_addr &&
        mreq_write == prev_write && mreq_wdata == prev_wdata))
      stab_viol++;
    prev_wait  = mreq_valid && !mreq_ready;
    prev_addr  = mreq_addr;
    prev_write = mreq_write;
    prev_wdata = mreq_wdata;
    if (mreq_valid && mreq_ready) begin
      if (mreq_write) begin
        if (n_wr < 32) begin wr_addr[n_wr] = mreq_addr; wr_data[n_wr] = mreq_wdata; end
        n_wr++;
      end else begin
        if (n_rd < 32) rd_log[n_rd] = mreq_addr;
        n_rd++;
        rd_addr_q = mreq_addr;
        rd_timer  = 2;
      end
    end
    if (cmd_valid && cmd_ready) begin
      if (n_cmd < 32) cmd_log[n_cmd] = cmd_data;
      n_cmd++;
    end
    if (irq) irq_cnt++;
    if (irq && irq_prev) irq_dbl++;
    irq_prev = irq;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic db_write(input bit sel, input logic [15:0] val);
    @(negedge clk);
    db_valid = 1'b1; db_sel = sel; db_data = val;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  // called at a falling edge
  task automatic post_cpl(input logic [15:0] cid, input logic [14:0] st);
    cpl_cid = cid; cpl_status = st; cpl_valid = 1'b1;
    while (!cpl_ready) @(negedge clk);
    @(posedge clk); #1 cpl_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset;
    chk(irq == 0, "R1 irq", 128'(irq), 0);
    chk(cmd_valid == 0, "R1 cmd_valid", 128'(cmd_valid), 0);
    chk(mreq_valid == 0, "R1 mreq_valid", 128'(mreq_valid), 0);
    chk(db_err == 0, "R1 db_err", 128'(db_err), 0);
    chk(cpl_ready == 1, "R1 cpl_ready", 128'(cpl_ready), 1);
  endtask

  task automatic t_basic;
    cmd_ready = 1'b1;
    db_write(0, 16'd2);
    wait_cyc(30);
    chk(n_rd == 2, "R3 read count", 128'(n_rd), 2);
    chk(rd_log[0] == 64'h1000, "R2 addr0", 128'(rd_log[0]), 128'h1000);
    chk(rd_log[1] == 64'h1040, "R2 addr1", 128'(rd_log[1]), 128'h1040);
    chk(n_cmd == 2, "R4 cmd count", 128'(n_cmd), 2);
    chk(cmd_log[1] == {8{64'h1040}}, "R4 cmd data", cmd_log[1][127:0], {2{64'h1040}});
  endtask

  task automatic t_backpressure;
    logic [511:0] held;
    cmd_ready = 1'b0;
    db_write(0, 16'd0);  // pending 2 and 3
    wait_cyc(20);
    chk(cmd_valid == 1, "R4 held valid", 128'(cmd_valid), 1);
    held = cmd_data;
    wait_cyc(10);
    chk(cmd_valid == 1 && cmd_data == held, "R4 held stable", cmd_data[127:0], held[127:0]);
    chk(n_rd == 3, "R4 no read while held", 128'(n_rd), 3);
    chk(rd_log[2] == 64'h1080, "R2 addr2", 128'(rd_log[2]), 128'h1080);
    cmd_ready = 1'b1;
    wait_cyc(30);
    chk(n_rd == 4, "R3 read count after release", 128'(n_rd), 4);
    chk(rd_log[3] == 64'h10C0, "R2 addr3", 128'(rd_log[3]), 128'h10C0);
    chk(n_cmd == 4, "R4 cmd count", 128'(n_cmd), 4);
  endtask

  task automatic t_wrap;
    db_write(0, 16'd2);  // head already wrapped to 0
    wait_cyc(30);
    chk(n_rd == 6, "R3 wrap count", 128'(n_rd), 6);
    chk(rd_log[4] == 64'h1000, "R3 wrap addr", 128'(rd_log[4]), 128'h1000);
    chk(rd_log[5] == 64'h1040, "R3 wrap addr next", 128'(rd_log[5]), 128'h1040);
  endtask

  task automatic t_bad_doorbell;
    db_write(0, 16'd4);
    wait_cyc(2);
    chk(db_err == 1, "R9 err set", 128'(db_err), 1);
    wait_cyc(20);
    chk(n_rd == 6, "R9 tail unchanged", 128'(n_rd), 6);
    db_write(1, 16'd7);
    wait_cyc(2);
    chk(cpl_ready == 1, "R9 head unchanged", 128'(cpl_ready), 1);
    chk(db_err == 1, "R9 err sticky", 128'(db_err), 1);
  endtask

  task automatic t_first_cpl;
    int i0;
    i0 = irq_cnt;
    post_cpl(16'hA1, 15'h5);
    wait_cyc(10);
    chk(n_wr == 1, "R5 write count", 128'(n_wr), 1);
    chk(wr_addr[0] == 64'h8000, "R5 addr", 128'(wr_addr[0]), 128'h8000);
    chk(wr_data[0] == {80'h0, 1'b1, 15'h5, 16'd2, 16'hA1}, "R5 R6 entry",
        wr_data[0], {80'h0, 1'b1, 15'h5, 16'd2, 16'hA1});
    chk(irq_cnt == i0 + 1, "R8 one pulse", 128'(irq_cnt), 128'(i0 + 1));
    chk(irq_dbl == 0, "R8 width", 128'(irq_dbl), 0);
  endtask

  task automatic t_full;
    post_cpl(16'hB1, 15'h1);
    post_cpl(16'hB2, 15'h2);
    wait_cyc(10);
    chk(cpl_ready == 0, "R7 full", 128'(cpl_ready), 0);
    cpl_cid = 16'hC3; cpl_status = 15'h3; cpl_valid = 1'b1;
    wait_cyc(20);
    chk(n_wr == 3, "R7 no overwrite", 128'(n_wr), 3);
    db_write(1, 16'd2);
    while (!cpl_ready) @(negedge clk);
    @(posedge clk); #1 cpl_valid = 1'b0;
    wait_cyc(10);
    chk(n_wr == 4, "R7 resumes", 128'(n_wr), 4);
    chk(wr_addr[3] == 64'h8030, "R5 addr slot3", 128'(wr_addr[3]), 128'h8030);
    chk(wr_data[3][47] == 1'b1 && wr_data[3][15:0] == 16'hC3, "R6 phase before wrap",
        wr_data[3][47:0], {1'b1, 15'h3, 16'd2, 16'hC3});
    post_cpl(16'hD4, 15'h0);
    wait_cyc(10);
    chk(wr_addr[4] == 64'h8000, "R5 addr wrapped", 128'(wr_addr[4]), 128'h8000);
    chk(wr_data[4][47] == 1'b0, "R6 phase inverted", 128'(wr_data[4][47]), 0);
    chk(irq_cnt == 5 && irq_dbl == 0, "R8 pulse count", 128'(irq_cnt), 5);
  endtask

  task automatic t_contention;
    db_write(1, 16'd0);
    rdy_mode = 1;
    db_write(0, 16'd0);  // pending 2 and 3
    post_cpl(16'hE5, 15'h7);
    wait_cyc(40);
    chk(n_rd == 8, "R3 reads under contention", 128'(n_rd), 8);
    chk(rd_log[6] == 64'h1080 && rd_log[7] == 64'h10C0, "R3 order",
        {rd_log[6], rd_log[7]}, {64'h1080, 64'h10C0});
    chk(n_wr == 6 && wr_addr[5] == 64'h8010, "R5 write under contention",
        128'(wr_addr[5]), 128'h8010);
    chk(wr_data[5][15:0] == 16'hE5 && wr_data[5][47:32] == {1'b0, 15'h7},
        "R6 phase and fields", wr_data[5][47:0], {1'b0, 15'h7, 16'h0, 16'hE5});
    chk(n_cmd == 8 && cmd_log[7] == {8{64'h10C0}}, "R4 data under contention",
        cmd_log[7][127:0], {2{64'h10C0}});
    chk(stab_viol == 0, "R10 request stable", 128'(stab_viol), 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_qsize = 17'd4;
    cfg_sq_base = 64'h1000; cfg_cq_base = 64'h8000;
    db_valid = 0; db_sel = 0; db_data = '0;
    cmd_ready = 0; cpl_valid = 0; cpl_cid = '0; cpl_status = '0;
    mreq_ready = 1'b1; mrsp_valid = 1'b0; mrsp_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_backpressure;
    t_wrap;
    t_bad_doorbell;
    t_first_cpl;
    t_full;
    t_contention;
    report;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report;
  end
endmodule